// File: doc/BRIEF.md
# Serial-Configured Front-End Register File

This block is the slow-control slave of a readout front end. A two-wire serial master (standard I2C, 7-bit addressing, slave only) uses it to program an operating-mode word, a trigger latency and nine 8-bit bias DAC codes. It also reads back a two-bit fault register. The device answers to a 7-bit address made of a fixed `001` prefix and four strap inputs. Strap value `1111` acts as a broadcast address, so one transfer can configure every device on a shared bus.

Access goes through a command byte. A write transfer carries the device address, the command byte and then one data byte. A read first sends a write transfer whose command byte has its least significant bit set. Each later read transfer returns one byte of the selected register, and the command does not need to be sent again. The serial data output is open drain. A broadcast read therefore gives the AND of all answering devices. Because the fault bits are active low, any one failing device pulls its bit to 0.

The two fault sources are a sticky queue-overflow flag, set by a pulse input, and a sticky latency flag, set whenever the latency register is written. A pipeline-reset pulse clears both flags. It does not touch the configuration values.

Top module: `fe_cfg_i2c`

## Requirements
- R1: The device acknowledges an address byte whose upper three bits are `001` and whose next four bits equal `addr_strap`. Any other address is not acknowledged, and the rest of that transaction changes no register.
- R2: Address bits `1111` after the `001` prefix are accepted for writes and reads whatever the strap value is.
- R3: In a write transfer, the byte after the address is the command. Its bits 7:1 select a register and bit 0 = 0 means write. The next byte is written to that register. Codes: 0x00 fault, 0x01 mode, 0x02 latency, 0x20+k DAC slot k (k = 0..8, slot k on `bias_o[8k+7:8k]`). Further bytes in the same transfer are not acknowledged and are ignored.
- R4: A command byte with bit 0 = 1 selects a register for reading, and any byte after it in that transfer is not acknowledged. Each later read transfer returns the selected register MSB first. Repeated read transfers return it again without a new command.
- R5: The fault register (code 0x00) reads as bits 7:2 = 1, bit 1 = NOT queue-fault and bit 0 = NOT latency-fault. A one-cycle `fifo_fault_i` pulse sets the queue fault, and it stays set until `pipe_reset_i`.
- R6: Writing the latency register sets the latency fault. The fault stays set until a `pipe_reset_i` pulse, which clears both faults.
- R7: The mode register is 3 bits, output on `mode_o`: bit 2 calibration inhibit, bit 1 peak (1) or deconvolution (0) processing, bit 0 analogue bias enable. It resets to `100` and is written from data bits 2:0. `pipe_reset_i` leaves it unchanged.
- R8: After reset, the latency register is 0x84 and all DAC codes are 0x00.
- R9: Writes to the fault register or to an unlisted code change no register. Reads of an unlisted code return 0x00.
- R10: `sda_pull_o` goes high only to acknowledge a byte or to send a 0 data bit. A device that is not addressed never pulls the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, many times the serial bit rate |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| addr_strap | input | 4 | Strapped low four device-address bits |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_pull_o | output | 1 | 1 = pull serial data low (open-drain drive) |
| fifo_fault_i | input | 1 | Pulse: queue overflow detected |
| pipe_reset_i | input | 1 | Pulse: pipeline restart, clears both faults |
| mode_o | output | 3 | Mode register value |
| latency_o | output | 8 | Latency register value |
| bias_o | output | 72 | Nine DAC codes, slot k at bits 8k+7:8k |

## Verification
A wrong bit state in the byte engine shows up within one byte time on the bus. Possible symptoms are a missing or extra acknowledge, a shifted or reversed read byte, or a later byte that gets acknowledged when it should be refused. A wrong register value or fault flag appears on the parallel outputs a few core cycles after the data byte's acknowledge. It also appears on the next read of that code. Random writes are each followed by a read-back, so a stale command, a mis-decoded code or a lost fault clear is exposed within one transaction pair.

// File: rtl/fe_cfg_pkg.sv
package fe_cfg_pkg;

    localparam logic [2:0] ADDR_PREFIX = 3'b001;
    localparam logic [3:0] BCAST_ID    = 4'hF;

    localparam logic [6:0] CODE_FAULT  = 7'h00;
    localparam logic [6:0] CODE_MODE   = 7'h01;
    localparam logic [6:0] CODE_LAT    = 7'h02;

    localparam logic [2:0] MODE_RST    = 3'b100;
    localparam logic [7:0] LAT_RST     = 8'h84;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } link_st_e;

    typedef struct packed {
        logic [1:0] scl_m;
        logic [1:0] sda_m;
        logic       scl_p;
        logic       sda_p;
    } sync_t;

    typedef struct packed {
        link_st_e   st;
        logic [7:0] sh;
        logic [3:0] cnt;
        logic [7:0] cmd;
        logic       rw;
        logic       pull;
        logic       wr_en;
        logic [6:0] wr_code;
        logic [7:0] wr_data;
    } link_t;

endpackage

// File: rtl/fe_cfg_sync.sv
module fe_cfg_sync
    import fe_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.scl_m = {s_q.scl_m[0], scl_i};
        s_d.sda_m = {s_q.sda_m[0], sda_i};
        s_d.scl_p = s_q.scl_m[1];
        s_d.sda_p = s_q.sda_m[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sda_s     = s_q.sda_m[1];
    assign scl_rise  = s_q.scl_m[1] & ~s_q.scl_p;
    assign scl_fall  = ~s_q.scl_m[1] & s_q.scl_p;
    assign bus_start = s_q.scl_m[1] & s_q.scl_p & s_q.sda_p & ~s_q.sda_m[1];
    assign bus_stop  = s_q.scl_m[1] & s_q.scl_p & ~s_q.sda_p & s_q.sda_m[1];

endmodule

// File: rtl/fe_cfg_link.sv
module fe_cfg_link
    import fe_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] addr_strap,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic [7:0] rd_data,
    output logic [6:0] rd_code,
    output logic       wr_en,
    output logic [6:0] wr_code,
    output logic [7:0] wr_data,
    output logic       sda_pull
);

    link_t l_d, l_q;
    logic  addr_hit;

    always_comb begin
        addr_hit = (l_q.sh[7:5] == ADDR_PREFIX) &&
                   ((l_q.sh[4:1] == addr_strap) || (l_q.sh[4:1] == BCAST_ID));
    end

    always_comb begin
        l_d       = l_q;
        l_d.wr_en = 1'b0;
        if (bus_stop) begin
            l_d.st   = ST_IDLE;
            l_d.pull = 1'b0;
        end else if (bus_start) begin
            l_d.st   = ST_ADDR;
            l_d.cnt  = '0;
            l_d.pull = 1'b0;
        end else begin
            unique case (l_q.st)
                ST_ADDR, ST_CMD, ST_DATA: begin
                    if (scl_rise) begin
                        l_d.sh  = {l_q.sh[6:0], sda_s};
                        l_d.cnt = l_q.cnt + 4'd1;
                    end else if (scl_fall && l_q.cnt == 4'd8) begin
                        l_d.cnt = '0;
                        if (l_q.st == ST_ADDR) begin
                            if (addr_hit) begin
                                l_d.pull = 1'b1;
                                l_d.rw   = l_q.sh[0];
                                l_d.st   = ST_ADDR_ACK;
                            end else begin
                                l_d.st   = ST_SKIP;
                            end
                        end else if (l_q.st == ST_CMD) begin
                            l_d.cmd  = l_q.sh;
                            l_d.pull = 1'b1;
                            l_d.st   = ST_CMD_ACK;
                        end else begin
                            l_d.pull    = 1'b1;
                            l_d.wr_en   = 1'b1;
                            l_d.wr_code = l_q.cmd[7:1];
                            l_d.wr_data = l_q.sh;
                            l_d.st      = ST_DATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        l_d.cnt = '0;
                        if (l_q.rw) begin
                            l_d.st   = ST_TX;
                            l_d.sh   = rd_data;
                            l_d.pull = ~rd_data[7];
                        end else begin
                            l_d.st   = ST_CMD;
                            l_d.pull = 1'b0;
                        end
                    end
                end
                ST_CMD_ACK: begin
                    if (scl_fall) begin
                        l_d.pull = 1'b0;
                        l_d.cnt  = '0;
                        l_d.st   = l_q.cmd[0] ? ST_SKIP : ST_DATA;
                    end
                end
                ST_DATA_ACK: begin
                    if (scl_fall) begin
                        l_d.pull = 1'b0;
                        l_d.st   = ST_SKIP;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        l_d.cnt = l_q.cnt + 4'd1;
                        if (l_q.cnt == 4'd7) begin
                            l_d.pull = 1'b0;
                            l_d.st   = ST_TX_ACK;
                        end else begin
                            l_d.sh   = {l_q.sh[6:0], 1'b0};
                            l_d.pull = ~l_q.sh[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_fall) begin
                        l_d.st = ST_SKIP;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q         <= '0;
            l_q.st      <= ST_IDLE;
        end else begin
            l_q <= l_d;
        end
    end

    assign rd_code  = l_q.cmd[7:1];
    assign wr_en    = l_q.wr_en;
    assign wr_code  = l_q.wr_code;
    assign wr_data  = l_q.wr_data;
    assign sda_pull = l_q.pull;

    // R10
    pull_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_q.pull |-> (l_q.st == ST_ADDR_ACK || l_q.st == ST_CMD_ACK ||
                      l_q.st == ST_DATA_ACK || l_q.st == ST_TX));

    // R1
    skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q.st == ST_SKIP || l_q.st == ST_IDLE) |-> !l_q.pull);

    // R4
    read_cmd_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l_q.wr_en |-> !l_q.cmd[0]);

endmodule

// File: rtl/fe_cfg_regs.sv
module fe_cfg_regs
    import fe_cfg_pkg::*;
#(
    parameter int         NUM_DAC  = 9,
    parameter logic [6:0] DAC_BASE = 7'h20,
    localparam int        BIAS_W   = 8 * NUM_DAC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [6:0]        wr_code,
    input  logic [7:0]        wr_data,
    input  logic [6:0]        rd_code,
    output logic [7:0]        rd_data,
    input  logic              fifo_fault_i,
    input  logic              pipe_reset_i,
    output logic [2:0]        mode_o,
    output logic [7:0]        latency_o,
    output logic [BIAS_W-1:0] bias_o
);

    typedef struct packed {
        logic [2:0]               mode;
        logic [7:0]               lat;
        logic [NUM_DAC-1:0][7:0]  dac;
        logic                     q_fault;
        logic                     l_fault;
    } regs_t;

    regs_t r_d, r_q;
    logic [NUM_DAC-1:0] dac_wsel;
    logic [NUM_DAC-1:0] dac_rsel;

    for (genvar gi = 0; gi < NUM_DAC; gi++) begin : g_slot
        assign dac_wsel[gi]          = wr_en && (wr_code == 7'(DAC_BASE + gi));
        assign dac_rsel[gi]          = (rd_code == 7'(DAC_BASE + gi));
        assign bias_o[8*gi +: 8]     = r_q.dac[gi];
    end

    always_comb begin
        r_d = r_q;
        if (pipe_reset_i) begin
            r_d.q_fault = 1'b0;
            r_d.l_fault = 1'b0;
        end
        if (fifo_fault_i) begin
            r_d.q_fault = 1'b1;
        end
        if (wr_en) begin
            if (wr_code == CODE_MODE) begin
                r_d.mode = wr_data[2:0];
            end else if (wr_code == CODE_LAT) begin
                r_d.lat     = wr_data;
                r_d.l_fault = 1'b1;
            end
        end
        for (int i = 0; i < NUM_DAC; i++) begin
            if (dac_wsel[i]) begin
                r_d.dac[i] = wr_data;
            end
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_code == CODE_FAULT) begin
            rd_data = {6'b111111, ~r_q.q_fault, ~r_q.l_fault};
        end else if (rd_code == CODE_MODE) begin
            rd_data = {5'b00000, r_q.mode};
        end else if (rd_code == CODE_LAT) begin
            rd_data = r_q.lat;
        end else begin
            for (int i = 0; i < NUM_DAC; i++) begin
                if (dac_rsel[i]) begin
                    rd_data = r_q.dac[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mode <= MODE_RST;
            r_q.lat  <= LAT_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign mode_o    = r_q.mode;
    assign latency_o = r_q.lat;

    // R6
    lat_write_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_code == CODE_LAT) |=> (rd_code != CODE_FAULT || !rd_data[0] || $changed(rd_code)));

    // R6
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_reset_i && !fifo_fault_i && !wr_en) |=> (!r_q.q_fault && !r_q.l_fault));

    // R7
    mode_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_reset_i && !wr_en) |=> $stable(mode_o));

    // R9
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(mode_o) && $stable(latency_o) && $stable(bias_o)));

endmodule

// File: rtl/fe_cfg_i2c.sv
module fe_cfg_i2c
    import fe_cfg_pkg::*;
#(
    parameter int         NUM_DAC  = 9,
    parameter logic [6:0] DAC_BASE = 7'h20,
    localparam int        BIAS_W   = 8 * NUM_DAC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        addr_strap,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic              fifo_fault_i,
    input  logic              pipe_reset_i,
    output logic [2:0]        mode_o,
    output logic [7:0]        latency_o,
    output logic [BIAS_W-1:0] bias_o
);

    logic       sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [7:0] rd_data;
    logic [6:0] rd_code;
    logic       wr_en;
    logic [6:0] wr_code;
    logic [7:0] wr_data;

    fe_cfg_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    fe_cfg_link u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_strap (addr_strap),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .rd_data    (rd_data),
        .rd_code    (rd_code),
        .wr_en      (wr_en),
        .wr_code    (wr_code),
        .wr_data    (wr_data),
        .sda_pull   (sda_pull_o)
    );

    fe_cfg_regs #(
        .NUM_DAC  (NUM_DAC),
        .DAC_BASE (DAC_BASE)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_code      (wr_code),
        .wr_data      (wr_data),
        .rd_code      (rd_code),
        .rd_data      (rd_data),
        .fifo_fault_i (fifo_fault_i),
        .pipe_reset_i (pipe_reset_i),
        .mode_o       (mode_o),
        .latency_o    (latency_o),
        .bias_o       (bias_o)
    );

endmodule

// File: tb/fe_cfg_i2c_bench.sv
`timescale 1ns/1ps
module fe_cfg_i2c_bench;

    localparam int Q = 8;
    localparam logic [3:0] STRAP = 4'b0101;
    localparam logic [6:0] OWN   = {3'b001, STRAP};
    localparam logic [6:0] BCAST = 7'b0011111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        fifo_fault = 1'b0;
    logic        pipe_reset = 1'b0;
    logic        sda_pull;
    logic        bus;
    logic [2:0]  mode_o;
    logic [7:0]  latency_o;
    logic [71:0] bias_o;

    int checks = 0;
    int errors = 0;

    logic [2:0]      e_mode;
    logic [7:0]      e_lat;
    logic [8:0][7:0] e_dac;
    logic            e_qf, e_lf;

    assign bus = m_sda & ~sda_pull;

    always #2 clk = ~clk;

    fe_cfg_i2c u_fe_cfg_i2c (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_strap   (STRAP),
        .scl_i        (scl),
        .sda_i        (bus),
        .sda_pull_o   (sda_pull),
        .fifo_fault_i (fifo_fault),
        .pipe_reset_i (pipe_reset),
        .mode_o       (mode_o),
        .latency_o    (latency_o),
        .bias_o       (bias_o)
    );

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [6:0] c);
        if (c == 7'h00) return {6'b111111, ~e_qf, ~e_lf};
        if (c == 7'h01) return {5'b0, e_mode};
        if (c == 7'h02) return e_lat;
        if (c >= 7'h20 && c <= 7'h28) return e_dac[c - 7'h20];
        return 8'h00;
    endfunction

    function automatic void model_wr(input logic [6:0] c, input logic [7:0] d);
        if (c == 7'h01) e_mode = d[2:0];
        else if (c == 7'h02) begin e_lat = d; e_lf = 1'b1; end
        else if (c >= 7'h20 && c <= 7'h28) e_dac[c - 7'h20] = d;
    endfunction

    function automatic logic [6:0] pick_code(input int k);
        if (k < 3) return 7'(k);
        if (k < 12) return 7'(7'h20 + k - 3);
        return 7'h55;
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        scl = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; wq();
        scl = 1'b1; wq();
        m_sda = 1'b1; wq(); wq();
    endtask

    task automatic wbit(input logic b);
        m_sda = b; wq();
        scl = 1'b1; wq(); wq();
        scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) wbit(b[i]);
        m_sda = 1'b1; wq();
        scl = 1'b1; wq();
        ack = ~bus;
        wq();
        scl = 1'b0; wq();
    endtask

    task automatic recv_byte(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wq();
            scl = 1'b1; wq();
            b[i] = bus;
            wq();
            scl = 1'b0; wq();
        end
        wbit(1'b1);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                            output logic ka, output logic kc, output logic kd);
        i2c_start();
        send_byte({a, 1'b0}, ka);
        send_byte(c, kc);
        send_byte(d, kd);
        i2c_stop();
        if (ka && !c[0]) model_wr(c[7:1], d);
    endtask

    task automatic do_fetch(input logic [6:0] a, output logic [7:0] b, output logic ka);
        i2c_start();
        send_byte({a, 1'b1}, ka);
        if (ka) recv_byte(b); else b = 8'hFF;
        i2c_stop();
    endtask

    task automatic do_read(input logic [6:0] a, input logic [6:0] c, output logic [7:0] b);
        logic k0, k1;
        i2c_start();
        send_byte({a, 1'b0}, k0);
        send_byte({c, 1'b1}, k1);
        i2c_stop();
        do_fetch(a, b, k0);
    endtask

    task automatic pulse_reset();
        @(negedge clk) pipe_reset = 1'b1;
        @(negedge clk) pipe_reset = 1'b0;
        e_qf = 1'b0; e_lf = 1'b0;
    endtask

    task automatic check_ports(input string req);
        check({req, " mode"}, 72'(mode_o), 72'(e_mode));
        check({req, " latency"}, 72'(latency_o), 72'(e_lat));
        check({req, " bias"}, bias_o, e_dac);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic ka, kc, kd, k2;
        logic [7:0] rb;
        void'($urandom(32'h1C2A_0B05));
        e_mode = 3'b100; e_lat = 8'h84; e_dac = '0; e_qf = 1'b0; e_lf = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R7 R8 reset values
        check_ports("R7 R8 reset");
        check("R10 idle no pull", 72'(sda_pull), 72'd0);

        // R5 fault register reads all-OK after reset
        do_read(OWN, 7'h00, rb);
        check("R5 fault after reset", 72'(rb), 72'hFF);

        // R1 R3 R7 mode write
        do_write(OWN, 8'h02, 8'h03, ka, kc, kd);
        check("R1 own addr ack", 72'({ka, kc, kd}), 72'b111);
        check_ports("R3 R7 mode write");

        // R6 latency write raises fault; R4 repeated read
        do_write(OWN, 8'h04, 8'h5A, ka, kc, kd);
        check_ports("R3 latency write");
        do_read(OWN, 7'h00, rb);
        check("R6 latency fault", 72'(rb), 72'hFE);
        do_fetch(OWN, rb, ka);
        check("R4 repeated read", 72'(rb), 72'hFE);

        // R6 R7 pipeline restart clears faults, keeps mode
        pulse_reset();
        repeat (4) @(negedge clk);
        check_ports("R7 restart keeps config");
        do_fetch(OWN, rb, ka);
        check("R6 restart clears", 72'(rb), 72'hFF);

        // R5 queue fault sticky
        @(negedge clk) fifo_fault = 1'b1;
        @(negedge clk) fifo_fault = 1'b0;
        e_qf = 1'b1;
        repeat (20) @(negedge clk);
        do_fetch(OWN, rb, ka);
        check("R5 queue fault", 72'(rb), 72'hFD);
        pulse_reset();
        do_fetch(OWN, rb, ka);
        check("R5 queue fault cleared", 72'(rb), 72'hFF);

        // R2 broadcast write and read
        do_write(BCAST, {7'h23, 1'b0}, 8'hC3, ka, kc, kd);
        check("R2 bcast ack", 72'(ka), 72'd1);
        check_ports("R2 bcast write");
        do_read(BCAST, 7'h23, rb);
        check("R2 bcast read", 72'(rb), 72'hC3);

        // R1 R10 wrong strap / wrong prefix ignored
        do_write({3'b001, 4'b0011}, {7'h20, 1'b0}, 8'h99, ka, kc, kd);
        check("R1 R10 strap mismatch nack", 72'({ka, kc, kd}), 72'b000);
        check_ports("R1 strap mismatch no change");
        do_write({3'b011, STRAP}, {7'h21, 1'b0}, 8'h77, ka, kc, kd);
        check("R1 prefix mismatch nack", 72'(ka), 72'd0);
        check_ports("R1 prefix mismatch no change");

        // R9 unlisted and fault-register writes discarded
        do_write(OWN, {7'h7F, 1'b0}, 8'h55, ka, kc, kd);
        check_ports("R9 unlisted write");
        do_write(OWN, {7'h00, 1'b0}, 8'h00, ka, kc, kd);
        do_read(OWN, 7'h00, rb);
        check("R9 fault write discarded", 72'(rb), 72'hFF);
        do_read(OWN, 7'h3C, rb);
        check("R9 unlisted read", 72'(rb), 72'h00);

        // R4 byte after read command refused
        i2c_start();
        send_byte({OWN, 1'b0}, ka);
        send_byte({7'h02, 1'b1}, kc);
        send_byte(8'h11, kd);
        i2c_stop();
        check("R4 byte after read cmd nack", 72'({ka, kc, kd}), 72'b110);
        check_ports("R4 no write after read cmd");

        // R3 extra byte after data refused
        i2c_start();
        send_byte({OWN, 1'b0}, ka);
        send_byte({7'h28, 1'b0}, kc);
        send_byte(8'h3E, kd);
        send_byte(8'h81, k2);
        i2c_stop();
        model_wr(7'h28, 8'h3E);
        check("R3 extra byte nack", 72'({kd, k2}), 72'b10);
        check_ports("R3 extra byte ignored");

        // random mix
        for (int n = 0; n < 24; n++) begin
            logic [6:0] c;
            logic [7:0] d;
            c = pick_code(int'($urandom % 13));
            d = 8'($urandom);
            do_write(OWN, {c, 1'b0}, d, ka, kc, kd);
            check("R3 random ack", 72'({ka, kc, kd}), 72'b111);
            check_ports("R3 R9 random write");
            if (($urandom % 4) == 0) pulse_reset();
            do_read(OWN, c, rb);
            check("R4 R5 random readback", 72'(rb), 72'(exp_rd(c)));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule